// File: doc/BRIEF.md
# One-Wire Slave ROM Command Handler

This block sits above the bit layer of a single-wire bus slave. After each bus reset it takes the received bytes and works through the ROM-level command set for one device. It decides whether the device is selected for the function-command phase that follows. It also keeps a speed flag that selects fast timing for the bit layer.

Two addressed commands are supported: a regular match and a match that also moves the device to fast timing. Each of them compares a 64-bit registration number against the device's own ID, one byte at a time and least-significant bit first. A successful addressed match sets a resume flag. With that flag set, a short resume command can select the device again later without resending the full ID. Skip selects the device without addressing it and clears that flag. A bus reset restarts the command sequence. Only a reset classified as long returns the device to regular speed.

Top module: `rom_cmd_handler`

## Requirements
- R1: After rstN is released, idle is 1, funcEnable is 0 and overdrive is 0. The resume flag is clear, so a resume command after the first bus reset leads to idle.
- R2: One cycle after a busReset pulse, idle and funcEnable are both 0 and the handler waits for a command byte. A partial ID in progress is discarded.
- R3: Command byte CCh (skip) sets funcEnable one cycle after its strobe and clears the resume flag.
- R4: Command byte 55h (match) is followed by eight ID bytes. Byte k is compared with devId[8k+7:8k], with bit 0 of the byte being the earliest bit on the wire. funcEnable stays 0 until the eighth byte matches. It becomes 1 one cycle after that byte's strobe, and the resume flag is then set.
- R5: A mismatch in any ID byte, including the last, sets idle one cycle after that byte and clears the resume flag. Later ID bytes do not reselect the device.
- R6: Command byte A5h (resume) with the resume flag set sets funcEnable, and the flag stays set.
- R7: Command byte A5h with the resume flag clear sets idle.
- R8: Command byte 69h (fast match) raises overdrive one cycle after its strobe. It then takes eight ID bytes exactly as in R4. A full match sets funcEnable and the resume flag, and overdrive stays 1. A later regular match leaves overdrive at 1.
- R9: A mismatch during a fast match sets idle and clears the resume flag. It returns overdrive to the value it had before the 69h byte.
- R10: A busReset with resetLong at 1 clears overdrive. A busReset with resetLong at 0 leaves overdrive unchanged.
- R11: Any other command byte sets idle and leaves the resume flag unchanged.
- R12: While funcEnable or idle is 1, received bytes change no output until the next busReset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rxByte | input | 8 | Byte from the bit layer |
| rxValid | input | 1 | One-cycle strobe qualifying rxByte |
| busReset | input | 1 | One-cycle pulse when a bus reset is detected |
| resetLong | input | 1 | Qualifies busReset: 1 for a long reset |
| devId | input | 64 | Device registration number |
| funcEnable | output | 1 | Device is selected for the function-command phase |
| overdrive | output | 1 | Fast bus timing is selected |
| idle | output | 1 | Device is deselected until the next bus reset |

## Verification
The bench uses the default parameters: a 64-bit ID, which is eight ID bytes, and the four default command codes. With eight bytes, a mismatch can be placed in the first byte, a middle byte or the last byte, so the abort path is tested at both ends of the byte counter. Fast-match failures are run from both starting speeds, which shows that the speed flag is restored and not simply cleared. Resume is tried after each event that should set or clear the resume flag.

// File: rtl/rom_cmd_pkg.sv
package rom_cmd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CMD  = 2'd1,
    ST_ADDR = 2'd2,
    ST_FUNC = 2'd3
  } romState_t;

  typedef struct packed {
    logic clrIdx;
    logic incIdx;
    logic setResume;
    logic clrResume;
    logic enterOd;
    logic restoreOd;
    logic dropOd;
  } romCtl_t;

endpackage

// File: rtl/rom_cmd_ctrl.sv
module rom_cmd_ctrl
  import rom_cmd_pkg::*;
#(
  parameter logic [7:0] CMD_MATCH    = 8'h55,
  parameter logic [7:0] CMD_SKIP     = 8'hCC,
  parameter logic [7:0] CMD_RESUME   = 8'hA5,
  parameter logic [7:0] CMD_OD_MATCH = 8'h69
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic [7:0] rxByte,
  input  logic      rxValid,
  input  logic      busReset,
  input  logic      resetLong,
  input  logic      byteMatch,
  input  logic      idxLast,
  input  logic      resumeFlag,
  output romState_t state,
  output romCtl_t   ctl
);

  romState_t nextState;
  logic      fastVariant;
  logic      fastVariantNext;

  always_comb begin
    nextState       = state;
    ctl             = '0;
    fastVariantNext = fastVariant;
    if (busReset) begin
      nextState  = ST_CMD;
      ctl.clrIdx = 1'b1;
      ctl.dropOd = resetLong;
    end else if (rxValid) begin
      unique case (state)
        ST_CMD: begin
          if (rxByte == CMD_SKIP) begin
            nextState     = ST_FUNC;
            ctl.clrResume = 1'b1;
          end else if (rxByte == CMD_RESUME) begin
            nextState = resumeFlag ? ST_FUNC : ST_IDLE;
          end else if (rxByte == CMD_MATCH) begin
            nextState       = ST_ADDR;
            ctl.clrIdx      = 1'b1;
            fastVariantNext = 1'b0;
          end else if (rxByte == CMD_OD_MATCH) begin
            nextState       = ST_ADDR;
            ctl.clrIdx      = 1'b1;
            ctl.enterOd     = 1'b1;
            fastVariantNext = 1'b1;
          end else begin
            nextState = ST_IDLE;
          end
        end
        ST_ADDR: begin
          if (!byteMatch) begin
            nextState     = ST_IDLE;
            ctl.clrResume = 1'b1;
            ctl.restoreOd = fastVariant;
          end else if (idxLast) begin
            nextState     = ST_FUNC;
            ctl.setResume = 1'b1;
          end else begin
            ctl.incIdx = 1'b1;
          end
        end
        default: nextState = state;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      fastVariant <= 1'b0;
    end else begin
      state       <= nextState;
      fastVariant <= fastVariantNext;
    end
  end

endmodule

// File: rtl/rom_cmd_dp.sv
module rom_cmd_dp
  import rom_cmd_pkg::*;
#(
  parameter int ID_W = 64
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [7:0]      rxByte,
  input  logic [ID_W-1:0] devId,
  input  romCtl_t         ctl,
  output logic            byteMatch,
  output logic            idxLast,
  output logic            resumeFlag,
  output logic            overdrive
);

  localparam int NUM_BYTES = ID_W / 8;
  localparam int IDX_W     = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_BYTES - 1);

  logic [IDX_W-1:0] byteIdx;
  logic             savedOd;
  logic [7:0]       expByte;

  // Byte k of the ID travels on the wire least-significant bit first
  assign expByte   = devId[byteIdx*8 +: 8];
  assign byteMatch = (rxByte == expByte);
  assign idxLast   = (byteIdx == LAST_IDX);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      byteIdx <= '0;
    end else if (ctl.clrIdx) begin
      byteIdx <= '0;
    end else if (ctl.incIdx) begin
      byteIdx <= byteIdx + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resumeFlag <= 1'b0;
    end else if (ctl.setResume) begin
      resumeFlag <= 1'b1;
    end else if (ctl.clrResume) begin
      resumeFlag <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      overdrive <= 1'b0;
      savedOd   <= 1'b0;
    end else if (ctl.dropOd) begin
      overdrive <= 1'b0;
    end else if (ctl.enterOd) begin
      savedOd   <= overdrive;
      overdrive <= 1'b1;
    end else if (ctl.restoreOd) begin
      overdrive <= savedOd;
    end
  end

endmodule

// File: rtl/rom_cmd_handler.sv
module rom_cmd_handler
  import rom_cmd_pkg::*;
#(
  parameter int         ID_W         = 64,
  parameter logic [7:0] CMD_MATCH    = 8'h55,
  parameter logic [7:0] CMD_SKIP     = 8'hCC,
  parameter logic [7:0] CMD_RESUME   = 8'hA5,
  parameter logic [7:0] CMD_OD_MATCH = 8'h69
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [7:0]      rxByte,
  input  logic            rxValid,
  input  logic            busReset,
  input  logic            resetLong,
  input  logic [ID_W-1:0] devId,
  output logic            funcEnable,
  output logic            overdrive,
  output logic            idle
);

  romState_t state;
  romCtl_t   ctl;
  logic      byteMatch;
  logic      idxLast;
  logic      resumeFlag;
  logic      cmdWait;

  rom_cmd_ctrl #(
    .CMD_MATCH   (CMD_MATCH),
    .CMD_SKIP    (CMD_SKIP),
    .CMD_RESUME  (CMD_RESUME),
    .CMD_OD_MATCH(CMD_OD_MATCH)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .rxByte    (rxByte),
    .rxValid   (rxValid),
    .busReset  (busReset),
    .resetLong (resetLong),
    .byteMatch (byteMatch),
    .idxLast   (idxLast),
    .resumeFlag(resumeFlag),
    .state     (state),
    .ctl       (ctl)
  );

  rom_cmd_dp #(
    .ID_W(ID_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .rxByte    (rxByte),
    .devId     (devId),
    .ctl       (ctl),
    .byteMatch (byteMatch),
    .idxLast   (idxLast),
    .resumeFlag(resumeFlag),
    .overdrive (overdrive)
  );

  assign funcEnable = (state == ST_FUNC);
  assign idle       = (state == ST_IDLE);
  assign cmdWait    = (state == ST_CMD);

endmodule

// File: rtl/rom_cmd_checker.sv
module rom_cmd_checker #(
  parameter logic [7:0] CMD_SKIP   = 8'hCC,
  parameter logic [7:0] CMD_RESUME = 8'hA5
) (
  input logic       clk,
  input logic       rstN,
  input logic [7:0] rxByte,
  input logic       rxValid,
  input logic       busReset,
  input logic       resetLong,
  input logic       funcEnable,
  input logic       overdrive,
  input logic       idle,
  input logic       resumeFlag,
  input logic       cmdWait
);

  // R2
  bus_reset_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    busReset |=> (!idle && !funcEnable));

  // R3
  skip_selects_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWait && rxValid && !busReset && rxByte == CMD_SKIP) |=> (funcEnable && !resumeFlag));

  // R6
  resume_granted_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWait && rxValid && !busReset && rxByte == CMD_RESUME && resumeFlag)
      |=> (funcEnable && resumeFlag));

  // R7
  resume_denied_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWait && rxValid && !busReset && rxByte == CMD_RESUME && !resumeFlag) |=> idle);

  // R10
  long_reset_speed_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busReset && resetLong) |=> !overdrive);

  // R10
  short_reset_speed_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busReset && !resetLong) |=> $stable(overdrive));

  // R12
  func_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (funcEnable && !busReset) |=> (funcEnable && $stable(overdrive)));

  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (idle && !busReset) |=> (idle && $stable(overdrive)));

endmodule

bind rom_cmd_handler rom_cmd_checker #(
  .CMD_SKIP  (CMD_SKIP),
  .CMD_RESUME(CMD_RESUME)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .rxByte    (rxByte),
  .rxValid   (rxValid),
  .busReset  (busReset),
  .resetLong (resetLong),
  .funcEnable(funcEnable),
  .overdrive (overdrive),
  .idle      (idle),
  .resumeFlag(resumeFlag),
  .cmdWait   (cmdWait)
);

// File: tb/test_rom_cmd_handler.sv
module test_rom_cmd_handler;

  localparam logic [63:0] MY_ID = 64'h1C2B_3A49_5867_7685;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  rxByte = '0;
  logic        rxValid = 1'b0;
  logic        busReset = 1'b0;
  logic        resetLong = 1'b0;
  logic [63:0] devId = MY_ID;
  logic        funcEnable;
  logic        overdrive;
  logic        idle;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  rom_cmd_handler i_rom_cmd_handler (
    .clk       (clk),
    .rstN      (rstN),
    .rxByte    (rxByte),
    .rxValid   (rxValid),
    .busReset  (busReset),
    .resetLong (resetLong),
    .devId     (devId),
    .funcEnable(funcEnable),
    .overdrive (overdrive),
    .idle      (idle)
  );

  // Expected vector order: {funcEnable, overdrive, idle}
  task automatic expectOut(input string req, input logic [2:0] exp);
    logic [2:0] act;
    act = {funcEnable, overdrive, idle};
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: {func,od,idle} actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic busRst(input logic isLong);
    @(negedge clk);
    busReset  = 1'b1;
    resetLong = isLong;
    @(negedge clk);
    busReset  = 1'b0;
    resetLong = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] b);
    @(negedge clk);
    rxByte  = b;
    rxValid = 1'b1;
    @(negedge clk);
    rxValid = 1'b0;
  endtask

  task automatic sendIdBytes(input logic [63:0] id, input int count);
    for (int k = 0; k < count; k++) sendByte(id[k*8 +: 8]);
  endtask

  task automatic matchOk(input logic [7:0] cmd);
    sendByte(cmd);
    sendIdBytes(MY_ID, 8);
  endtask

  task automatic tReset();
    expectOut("R1 reset outputs", 3'b001);
    busRst(1'b1);
    sendByte(8'hA5);
    expectOut("R1 resume flag clear after reset", 3'b001);
  endtask

  task automatic tBusReset();
    busRst(1'b1);
    expectOut("R2 waiting for command", 3'b000);
    sendByte(8'h55);
    sendIdBytes(MY_ID, 3);
    busRst(1'b0);
    expectOut("R2 restart after partial ID", 3'b000);
    matchOk(8'h55);
    expectOut("R2 partial ID discarded", 3'b100);
  endtask

  task automatic tSkip();
    busRst(1'b1);
    sendByte(8'hCC);
    expectOut("R3 skip selects", 3'b100);
    sendByte(8'hFF);
    sendByte(8'h00);
    expectOut("R12 bytes in function phase ignored", 3'b100);
    busRst(1'b1);
    matchOk(8'h55);
    busRst(1'b1);
    sendByte(8'hCC);
    busRst(1'b1);
    sendByte(8'hA5);
    expectOut("R3 skip cleared resume flag", 3'b001);
  endtask

  task automatic tMatch();
    busRst(1'b1);
    sendByte(8'h55);
    sendIdBytes(MY_ID, 7);
    expectOut("R4 not selected before last byte", 3'b000);
    sendByte(MY_ID[63:56]);
    expectOut("R4 full match selects", 3'b100);
    busRst(1'b1);
    sendByte(8'hA5);
    expectOut("R6 resume after match", 3'b100);
    busRst(1'b1);
    sendByte(8'hA5);
    expectOut("R6 resume flag kept", 3'b100);
  endtask

  task automatic tMismatch();
    logic [63:0] badId;
    busRst(1'b1);
    matchOk(8'h55);
    badId = MY_ID;
    badId[27] = ~badId[27];
    busRst(1'b1);
    sendByte(8'h55);
    sendIdBytes(badId, 4);
    expectOut("R5 middle byte mismatch", 3'b001);
    sendIdBytes(MY_ID, 8);
    expectOut("R5 later bytes ignored", 3'b001);
    busRst(1'b1);
    sendByte(8'hA5);
    expectOut("R7 resume denied after mismatch", 3'b001);
    badId = MY_ID;
    badId[63] = ~badId[63];
    busRst(1'b1);
    sendByte(8'h55);
    sendIdBytes(badId, 8);
    expectOut("R5 last byte mismatch", 3'b001);
    badId = MY_ID;
    badId[0] = ~badId[0];
    busRst(1'b1);
    sendByte(8'h55);
    sendIdBytes(badId, 1);
    expectOut("R5 first bit mismatch", 3'b001);
  endtask

  task automatic tUnknown();
    busRst(1'b1);
    matchOk(8'h55);
    busRst(1'b1);
    sendByte(8'hF0);
    expectOut("R11 unknown command idles", 3'b001);
    busRst(1'b1);
    sendByte(8'hA5);
    expectOut("R11 resume flag unchanged", 3'b100);
  endtask

  task automatic tFastMatch();
    busRst(1'b1);
    sendByte(8'h69);
    expectOut("R8 fast speed after command", 3'b010);
    sendIdBytes(MY_ID, 8);
    expectOut("R8 fast match selects", 3'b110);
    busRst(1'b0);
    expectOut("R10 short reset keeps speed", 3'b010);
    sendByte(8'hA5);
    expectOut("R8 resume after fast match", 3'b110);
    busRst(1'b0);
    matchOk(8'h55);
    expectOut("R8 regular match keeps fast speed", 3'b110);
    busRst(1'b1);
    expectOut("R10 long reset drops speed", 3'b000);
  endtask

  task automatic tFastFail();
    logic [63:0] badId;
    badId = MY_ID;
    badId[5] = ~badId[5];
    busRst(1'b1);
    sendByte(8'h69);
    sendIdBytes(badId, 1);
    expectOut("R9 failed fast match from regular", 3'b001);
    busRst(1'b1);
    matchOk(8'h69);
    busRst(1'b0);
    badId = MY_ID;
    badId[40] = ~badId[40];
    sendByte(8'h69);
    sendIdBytes(badId, 6);
    expectOut("R9 failed fast match keeps prior fast", 3'b011);
    busRst(1'b0);
    sendByte(8'hA5);
    expectOut("R9 resume cleared by fast mismatch", 3'b011);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tBusReset();
    tSkip();
    tMatch();
    tMismatch();
    tUnknown();
    tFastMatch();
    tFastFail();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule